// File: doc/BRIEF.md
# Multi-Wire Transition Symbol Decoder

This block sits on the receive side of a low-speed multi-wire bus. Data is carried in the change of the wire state from one slot to the next, not in the levels themselves. On each slot strobe the decoder compares the sampled wires with the state it saw at the previous slot. The XOR of the two is a symbol that can never be zero in legal traffic, so it takes one of s = 2^n − 1 values. Subtracting one gives a base-s digit.

A fixed number of digits forms one chunk of message bits. The decoder folds the digits into an unsigned integer, most significant digit first, and presents the result as a binary chunk with a one-cycle valid pulse. For three wires, five base-7 digits carry a 14-bit chunk. For two wires, seven base-3 digits carry 11 bits. For four wires, three base-15 digits carry 11 bits. A zero symbol or an out-of-range value raises a one-cycle error pulse instead. A start-of-message strobe realigns the digit count. Clock recovery, CRC checking and framing above chunk level belong to other blocks.

Top module: `mwt_decoder`

## Requirements
- R1: After reset `chunk_valid_o` and `sym_err_o` are 0 and `chunk_o` is 0. The stored previous wire state is all zeros, so a first slot with all wires low is a zero symbol.
- R2: On a slot the symbol is `wires_i` XOR the wires sampled at the previous slot. The digit is the symbol minus one, for example symbol 3'b001 gives digit 0 and 3'b111 gives digit 6 when n = 3.
- R3: With n = 3, five consecutive nonzero slots form one chunk computed as value = value·7 + digit, starting from 0, with the first slot's digit most significant. The result appears on the 14-bit `chunk_o`.
- R4: `chunk_valid_o` is high for exactly one cycle, the cycle after the clock edge that samples the last digit. `chunk_o` changes only when `chunk_valid_o` is high and otherwise holds its last value.
- R5: A slot whose symbol is zero makes `sym_err_o` high for one cycle after that edge and discards the partial chunk. The next nonzero slot is the first digit of a new chunk.
- R6: If the completed value is 2^14 or more (for example 16384, or 16806 from five digits of 6), `sym_err_o` pulses in place of `chunk_valid_o`, and no chunk is emitted.
- R7: `sof_i` discards any partial chunk. When `sof_i` and `slot_i` are high in the same cycle, that slot's digit is the first, most significant digit of a new chunk.
- R8: While `slot_i` is low, changes on `wires_i` do not affect the stored wire state, the partial chunk or the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wires_i | input | N_WIRES | Synchronized bus wire levels |
| slot_i | input | 1 | Sample strobe, one cycle per slot |
| sof_i | input | 1 | Start-of-message strobe, clears digit alignment |
| chunk_o | output | CHUNK_BITS | Last decoded chunk |
| chunk_valid_o | output | 1 | One-cycle pulse when a new chunk is on `chunk_o` |
| sym_err_o | output | 1 | One-cycle pulse on a zero symbol or an overflowing chunk |

## Verification
A wrong stored wire state shows up at the next slot as a wrong digit, and so as a wrong chunk value. It can also show up as a false error pulse. In either case it is visible within one chunk time. A digit counter that is off by one shifts every later chunk by a digit, which breaks the value compare at the very next valid pulse. A bad overflow limit shows up only near the top of the value range. The sweep over all 16384 chunk values catches it, as do the two values just past the limit. A partial chunk that survives an error or a start strobe corrupts the first chunk that follows, and the bench checks that chunk directly.

// File: rtl/mwt_pkg.sv
package mwt_pkg;

  // Number of legal transition symbols for n wires.
  function automatic int radix_of(input int n_wires);
    return (1 << n_wires) - 1;
  endfunction

  // Binary chunk width carried per group of digits.
  function automatic int chunk_bits_of(input int n_wires);
    return (n_wires == 3) ? 14 : 11;
  endfunction

  // Digits needed so that radix^digits covers 2^chunk_bits.
  function automatic int digits_of(input int n_wires);
    case (n_wires)
      2:       return 7;
      3:       return 5;
      default: return 3;
    endcase
  endfunction

  // One multiply-accumulate step of the radix conversion.
  function automatic int unsigned fold_digit(input int unsigned acc,
                                             input int unsigned radix,
                                             input int unsigned digit);
    return acc * radix + digit;
  endfunction

  // True when the value fits in the binary chunk.
  function automatic logic fits_chunk(input int unsigned value,
                                      input int           bits);
    return value < (32'd1 << bits);
  endfunction

endpackage

// File: rtl/mwt_sym_stage.sv
module mwt_sym_stage #(
  parameter int N_WIRES = 3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_WIRES-1:0] wires_i,
  input  logic               slot_i,
  output logic               sym_zero_o,
  output logic [N_WIRES-1:0] digit_o
);

  logic [N_WIRES-1:0] prev_q;
  logic [N_WIRES-1:0] sym;

  assign sym        = wires_i ^ prev_q;
  assign sym_zero_o = (sym == '0);
  assign digit_o    = sym - N_WIRES'(1);

  always_ff @(posedge clk) begin
    if (!rst_n)      prev_q <= '0;
    else if (slot_i) prev_q <= wires_i;
  end

  // R8
  prev_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_i |=> $stable(prev_q));

endmodule

// File: rtl/mwt_digit_accum.sv
module mwt_digit_accum
  import mwt_pkg::*;
#(
  parameter int N_WIRES = 3,
  parameter int RADIX   = radix_of(N_WIRES),
  parameter int DIGITS  = digits_of(N_WIRES),
  parameter int ACC_W   = $clog2(RADIX ** DIGITS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               slot_i,
  input  logic               sof_i,
  input  logic               sym_zero_i,
  input  logic [N_WIRES-1:0] digit_i,
  output logic               done_o,
  output logic [ACC_W-1:0]   value_o
);

  localparam int CNT_W = (DIGITS > 1) ? $clog2(DIGITS) : 1;

  logic [CNT_W-1:0] cnt_q, cnt_base;
  logic [ACC_W-1:0] acc_q, acc_base;
  logic             take;
  logic             last;

  // A start strobe realigns before the current slot is counted.
  assign cnt_base = sof_i ? '0 : cnt_q;
  assign acc_base = sof_i ? '0 : acc_q;
  assign take     = slot_i && !sym_zero_i;
  assign last     = (cnt_base == CNT_W'(DIGITS - 1));
  assign value_o  = ACC_W'(fold_digit(32'(acc_base), RADIX, 32'(digit_i)));
  assign done_o   = take && last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (slot_i && sym_zero_i) begin
      cnt_q <= '0;
      acc_q <= '0;
    end else if (take) begin
      if (last) begin
        cnt_q <= '0;
        acc_q <= '0;
      end else begin
        cnt_q <= cnt_base + CNT_W'(1);
        acc_q <= value_o;
      end
    end else if (sof_i) begin
      cnt_q <= '0;
      acc_q <= '0;
    end
  end

  // R3
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q < CNT_W'(DIGITS));

  // R5
  zero_discard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_i && sym_zero_i |=> cnt_q == '0 && acc_q == '0);

  // R7
  sof_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sof_i && !slot_i |=> cnt_q == '0);

endmodule

// File: rtl/mwt_chunk_emit.sv
module mwt_chunk_emit
  import mwt_pkg::*;
#(
  parameter int CHUNK_BITS = 14,
  parameter int ACC_W      = 15
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  done_i,
  input  logic [ACC_W-1:0]      value_i,
  input  logic                  zero_err_i,
  output logic [CHUNK_BITS-1:0] chunk_o,
  output logic                  valid_o,
  output logic                  err_o
);

  logic in_range;
  logic overflow;

  assign in_range = fits_chunk(32'(value_i), CHUNK_BITS);
  assign overflow = done_i && !in_range;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chunk_o <= '0;
      valid_o <= 1'b0;
      err_o   <= 1'b0;
    end else begin
      valid_o <= done_i && in_range;
      err_o   <= zero_err_i || overflow;
      if (done_i && in_range) chunk_o <= CHUNK_BITS'(value_i);
    end
  end

  // R4
  no_dual_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(valid_o && err_o));

  // R4
  chunk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(chunk_o));

  // R6
  overflow_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |=> err_o && !valid_o);

endmodule

// File: rtl/mwt_decoder.sv
module mwt_decoder
  import mwt_pkg::*;
#(
  parameter int N_WIRES    = 3,
  parameter int CHUNK_BITS = chunk_bits_of(N_WIRES)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [N_WIRES-1:0]    wires_i,
  input  logic                  slot_i,
  input  logic                  sof_i,
  output logic [CHUNK_BITS-1:0] chunk_o,
  output logic                  chunk_valid_o,
  output logic                  sym_err_o
);

  localparam int RADIX  = radix_of(N_WIRES);
  localparam int DIGITS = digits_of(N_WIRES);
  localparam int ACC_W  = $clog2(RADIX ** DIGITS);

  logic               sym_zero;
  logic [N_WIRES-1:0] digit;
  logic               chunk_done;
  logic [ACC_W-1:0]   chunk_value;
  logic               zero_err;

  assign zero_err = slot_i && sym_zero;

  mwt_sym_stage #(.N_WIRES(N_WIRES)) u_sym (
    .clk        (clk),
    .rst_n      (rst_n),
    .wires_i    (wires_i),
    .slot_i     (slot_i),
    .sym_zero_o (sym_zero),
    .digit_o    (digit)
  );

  mwt_digit_accum #(
    .N_WIRES (N_WIRES),
    .RADIX   (RADIX),
    .DIGITS  (DIGITS),
    .ACC_W   (ACC_W)
  ) u_acc (
    .clk        (clk),
    .rst_n      (rst_n),
    .slot_i     (slot_i),
    .sof_i      (sof_i),
    .sym_zero_i (sym_zero),
    .digit_i    (digit),
    .done_o     (chunk_done),
    .value_o    (chunk_value)
  );

  mwt_chunk_emit #(
    .CHUNK_BITS (CHUNK_BITS),
    .ACC_W      (ACC_W)
  ) u_emit (
    .clk        (clk),
    .rst_n      (rst_n),
    .done_i     (chunk_done),
    .value_i    (chunk_value),
    .zero_err_i (zero_err),
    .chunk_o    (chunk_o),
    .valid_o    (chunk_valid_o),
    .err_o      (sym_err_o)
  );

  // R5
  zero_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    zero_err |=> sym_err_o);

  // R4
  valid_after_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    chunk_valid_o |-> $past(slot_i));

  // R8
  quiet_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !slot_i |=> !chunk_valid_o && !sym_err_o);

endmodule

// File: tb/test_mwt_decoder.sv
module test_mwt_decoder;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  wires_i = '0;
  logic        slot_i = 1'b0;
  logic        sof_i = 1'b0;
  logic [13:0] chunk_o;
  logic        chunk_valid_o;
  logic        sym_err_o;

  int n_checks = 0;
  int n_fail   = 0;
  logic [2:0] bprev = '0;

  always #5 clk = ~clk;

  mwt_decoder i_mwt_decoder (
    .clk           (clk),
    .rst_n         (rst_n),
    .wires_i       (wires_i),
    .slot_i        (slot_i),
    .sof_i         (sof_i),
    .chunk_o       (chunk_o),
    .chunk_valid_o (chunk_valid_o),
    .sym_err_o     (sym_err_o)
  );

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  endtask

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Drive one slot carrying transition symbol sym; returns at the next
  // falling edge, where the registered outputs of that slot are visible.
  task automatic drive_sym(input logic [2:0] sym, input bit sof);
    bprev   = bprev ^ sym;
    wires_i = bprev;
    slot_i  = 1'b1;
    sof_i   = sof;
    @(negedge clk);
    slot_i  = 1'b0;
    sof_i   = 1'b0;
  endtask

  // Send the base-7 digits of v, most significant first (n = 3).
  task automatic send_chunk(input int v, input bit sof_first);
    for (int k = 0; k < 5; k++) begin
      int div = 1;
      for (int j = 0; j < 4 - k; j++) div = div * 7;
      drive_sym(3'((v / div) % 7 + 1), sof_first && (k == 0));
    end
  endtask

  task automatic expect_chunk(input int v, input string req);
    check(chunk_valid_o === 1'b1 && sym_err_o === 1'b0 && chunk_o === 14'(v),
          req, int'(chunk_o), v);
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    summary();
  end

  initial begin
    logic [13:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    check(chunk_valid_o === 1'b0 && sym_err_o === 1'b0 && chunk_o === '0,
          "R1 reset outputs", int'({chunk_valid_o, sym_err_o}), 0);

    // R1 R5: stored state is zero, so all-low wires form a zero symbol
    drive_sym(3'b000, 1'b0);
    check(sym_err_o === 1'b1 && chunk_valid_o === 1'b0, "R1 zero prev state",
          int'(sym_err_o), 1);

    // R2 R3: every chunk value, back to back
    for (int v = 0; v < 16384; v++) begin
      send_chunk(v, 1'b0);
      expect_chunk(v, "R2 R3 sweep");
      if (v % 4096 == 0) begin
        @(negedge clk);
        // R4 valid is a single-cycle pulse, value held
        check(chunk_valid_o === 1'b0 && chunk_o === 14'(v), "R4 pulse width",
              int'(chunk_valid_o), 0);
      end
    end

    // R5: zero symbol discards a partial chunk
    drive_sym(3'd3, 1'b0);
    drive_sym(3'd5, 1'b0);
    drive_sym(3'd0, 1'b0);
    check(sym_err_o === 1'b1 && chunk_valid_o === 1'b0, "R5 zero symbol error",
          int'(sym_err_o), 1);
    send_chunk(12345, 1'b0);
    expect_chunk(12345, "R5 restart after error");

    // R6: values at and beyond 2^14
    send_chunk(16384, 1'b0);
    check(sym_err_o === 1'b1 && chunk_valid_o === 1'b0, "R6 overflow 16384",
          int'(chunk_valid_o), 0);
    send_chunk(16806, 1'b0);
    check(sym_err_o === 1'b1 && chunk_valid_o === 1'b0 && chunk_o === 14'd12345,
          "R6 overflow 16806", int'(chunk_o), 12345);

    // R7: start strobe alone clears a partial chunk
    drive_sym(3'd2, 1'b0);
    drive_sym(3'd6, 1'b0);
    drive_sym(3'd4, 1'b0);
    sof_i = 1'b1;
    @(negedge clk);
    sof_i = 1'b0;
    send_chunk(777, 1'b0);
    expect_chunk(777, "R7 sof alone");

    // R7: start strobe with a slot makes that slot the first digit
    drive_sym(3'd7, 1'b0);
    drive_sym(3'd1, 1'b0);
    send_chunk(4321, 1'b1);
    expect_chunk(4321, "R7 sof with slot");

    // R8: wire activity without a slot is ignored
    held = chunk_o;
    drive_sym(3'd4, 1'b0);
    for (int i = 0; i < 8; i++) begin
      wires_i = 3'(i);
      @(negedge clk);
      check(chunk_valid_o === 1'b0 && sym_err_o === 1'b0 && chunk_o === held,
            "R8 idle wires", int'(chunk_o), int'(held));
    end
    // 3*2401 = 7203 was already started by the digit-3 slot above
    drive_sym(3'd1, 1'b0);
    drive_sym(3'd1, 1'b0);
    drive_sym(3'd1, 1'b0);
    drive_sym(3'd2, 1'b0);
    expect_chunk(3 * 2401 + 1, "R8 chunk across idle");

    summary();
  end

endmodule